// File: doc/BRIEF.md
# Issue-Time Execution Port Assigner

This block gives every uop of an issue group an execution port at the moment the group enters the scheduler. The core has four ALU-capable ports, called port 0, port 1, port 5 and port 6. For each port the block keeps a count of the uops that are assigned to it and still waiting. A plain ALU uop goes to the port with the smallest count. A taken-branch uop can only run on port 6, so it always goes there. Once a port is chosen it never changes, even if the counts move before the uop dispatches.

An issue group has up to `GROUP` lanes. Lane 0 is the oldest. The lanes are assigned in that order, and each lane sees the counts after the earlier lanes of the same group have been added. The scheduler sends a one-cycle pulse for each port whenever that port dispatches a uop, and the matching count drops by one. When the scheduler is nearly empty, the counts are close together. ALU uops can then land on port 6 and compete with branches, and nothing in the counts prevents this. The assignment is combinational: it is valid in the same cycle the group is presented, and the counts update at the next clock edge.

Top module: `port_assigner`

## Requirements
- R1: After reset every port count is zero, so a full group of four ALU uops on an empty scheduler receives port indices 0, 1, 2, 3 in lanes 0..3. This includes port 6 for lane 3.
- R2: `out_port` holds a 2-bit index per lane at bits [2g+1:2g]. The encoding is 0 = port 0, 1 = port 1, 2 = port 5 and 3 = port 6.
- R3: A valid lane with `in_is_br` set is assigned index 3 (port 6) whatever the counts are.
- R4: A valid ALU lane is assigned the port with the lowest count. When counts are equal, the lower index wins, in the order 0, 1, 5, 6.
- R5: Lanes are resolved from lane 0 upward. Each valid earlier lane, branch or ALU, adds one to its port's count as seen by the later lanes of the same group.
- R6: A lane with `in_valid` low drives `out_valid` low and `out_port` index 0, and it is not counted.
- R7: At each clock edge a port's count rises by the number of lanes assigned to it in that cycle. It falls by one if that port's `dispatch` bit is high. A group issued in the same cycle as a dispatch sees the counts from before that edge.
- R8: A dispatch pulse for a port whose count is zero is ignored, and the count stays zero.
- R9: A count saturates at 2^CNT_W-1 and never wraps.
- R10: `out_valid` and `out_port` depend combinationally on the inputs and the current counts, and are valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | GROUP | Lane holds a uop to issue |
| in_is_br | input | GROUP | Lane uop is a taken branch |
| dispatch | input | 4 | Per-port dispatch pulse (bit = port index) |
| out_valid | output | GROUP | Lane received a port this cycle |
| out_port | output | 2*GROUP | Per-lane port index |

## Verification
The assertions check on every cycle that:
- branches land on port 6;
- idle lanes stay uncounted and drive index 0;
- each ALU choice is no worse than any other port under the tie order;
- every lane grants at most one port;
- a count never moves in the wrong direction, never leaves zero on a dispatch to an empty port, and holds at its ceiling.

Only the directed scenarios can show the results that depend on history:
- how counts carry across cycles and across lanes of a group;
- how a same-cycle dispatch interacts with an issue;
- how an almost-empty scheduler lets an ALU uop take port 6;
- what a saturated count looks like after a long drain.

// File: rtl/pa_pkg.sv
package pa_pkg;
  localparam int NPORT  = 4;
  localparam int PIDX_W = 2;
  localparam logic [PIDX_W-1:0] BR_PORT = 2'd3;

  typedef logic [15:0] wcnt_t;
  typedef logic [PIDX_W-1:0] pidx_t;

  // lowest count wins; strict compare keeps the lower index on ties
  function automatic pidx_t lowest_port(input wcnt_t [NPORT-1:0] c);
    pidx_t best;
    best = '0;
    for (int i = 1; i < NPORT; i++) begin
      if (c[i] < c[best]) best = pidx_t'(i);
    end
    return best;
  endfunction

  // saturating add of issued uops, minus one dispatch when non-empty
  function automatic wcnt_t next_count(input wcnt_t cur, input wcnt_t add,
                                       input logic dsp, input wcnt_t maxv);
    wcnt_t s;
    s = cur + add;
    if (dsp && cur != '0) s = s - 16'd1;
    if (s > maxv) s = maxv;
    return s;
  endfunction
endpackage

// File: rtl/pa_lane_pick.sv
module pa_lane_pick
  import pa_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   valid_i,
  input  logic                   is_br_i,
  input  wcnt_t [NPORT-1:0]      cnt_i,
  output pidx_t                  port_o,
  output logic  [NPORT-1:0]      grant_o,
  output wcnt_t [NPORT-1:0]      cnt_o
);
  pidx_t alu_pick;

  always_comb begin
    alu_pick = lowest_port(cnt_i);
    if (!valid_i)      port_o = '0;
    else if (is_br_i)  port_o = BR_PORT;
    else               port_o = alu_pick;
    grant_o = '0;
    if (valid_i) grant_o[port_o] = 1'b1;
    for (int p = 0; p < NPORT; p++) begin
      cnt_o[p] = cnt_i[p] + wcnt_t'(grant_o[p]);
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_opt
    // R4
    alu_lower_tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && !is_br_i && port_o > pidx_t'(p)) |-> (cnt_i[port_o] < cnt_i[p]));
    // R4
    alu_not_worse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && !is_br_i) |-> (cnt_i[port_o] <= cnt_i[p]));
  end

  // R5
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o) && (valid_i == (grant_o != '0)));
endmodule

// File: rtl/pa_port_counter.sv
module pa_port_counter
  import pa_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int ADD_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ADD_W-1:0] add_i,
  input  logic             dispatch_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam wcnt_t MAXV = wcnt_t'((1 << CNT_W) - 1);

  logic [CNT_W-1:0] cnt_q;
  wcnt_t            nxt;
  logic             disp_ignored;
  logic             at_ceiling;

  always_comb begin
    nxt          = next_count(wcnt_t'(cnt_q), wcnt_t'(add_i), dispatch_i, MAXV);
    disp_ignored = dispatch_i && (cnt_q == '0);
    at_ceiling   = (wcnt_t'(cnt_q) == MAXV);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= CNT_W'(nxt);
  end

  assign cnt_o = cnt_q;

  // R8
  empty_disp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_ignored && add_i == '0) |=> (cnt_q == '0));
  // R7
  no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dispatch_i |=> (cnt_q >= $past(cnt_q)));
  // R7
  one_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dispatch_i && add_i == '0 && !disp_ignored) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_ceiling && !dispatch_i) |=> (wcnt_t'(cnt_q) == MAXV));
endmodule

// File: rtl/port_assigner.sv
module port_assigner
  import pa_pkg::*;
#(
  parameter int GROUP = 4,
  parameter int CNT_W = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [GROUP-1:0]        in_valid,
  input  logic [GROUP-1:0]        in_is_br,
  input  logic [NPORT-1:0]        dispatch,
  output logic [GROUP-1:0]        out_valid,
  output logic [PIDX_W*GROUP-1:0] out_port
);
  localparam int ADD_W = $clog2(GROUP + 1);

  logic [CNT_W-1:0]  cnt    [NPORT];
  wcnt_t [NPORT-1:0] chain  [GROUP+1];
  logic  [NPORT-1:0] grant  [GROUP];
  pidx_t             lane_port [GROUP];
  logic  [ADD_W-1:0] add    [NPORT];

  always_comb begin
    for (int p = 0; p < NPORT; p++) chain[0][p] = wcnt_t'(cnt[p]);
  end

  for (genvar g = 0; g < GROUP; g++) begin : g_lane
    pa_lane_pick u_pick (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid_i (in_valid[g]),
      .is_br_i (in_is_br[g]),
      .cnt_i   (chain[g]),
      .port_o  (lane_port[g]),
      .grant_o (grant[g]),
      .cnt_o   (chain[g+1])
    );
    assign out_port[PIDX_W*g +: PIDX_W] = lane_port[g];
    assign out_valid[g] = in_valid[g];

    // R3
    br_port6_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[g] && in_is_br[g]) |-> (out_port[PIDX_W*g +: PIDX_W] == BR_PORT));
    // R6
    idle_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid[g] |-> (!out_valid[g] && out_port[PIDX_W*g +: PIDX_W] == '0 && grant[g] == '0));
  end

  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      add[p] = '0;
      for (int g = 0; g < GROUP; g++) add[p] = add[p] + ADD_W'(grant[g][p]);
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    pa_port_counter #(.CNT_W(CNT_W), .ADD_W(ADD_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .add_i      (add[p]),
      .dispatch_i (dispatch[p]),
      .cnt_o      (cnt[p])
    );
  end

  // R7
  group_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(add[0]) + int'(add[1]) + int'(add[2]) + int'(add[3])) == $countones(in_valid));
endmodule

// File: tb/sim_port_assigner.sv
module sim_port_assigner;
  localparam int GROUP = 4;
  localparam int CNT_W = 5;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [GROUP-1:0] in_valid;
  logic [GROUP-1:0] in_is_br;
  logic [3:0]       dispatch;
  logic [GROUP-1:0] out_valid;
  logic [2*GROUP-1:0] out_port;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  port_assigner #(.GROUP(GROUP), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_is_br(in_is_br),
    .dispatch(dispatch), .out_valid(out_valid), .out_port(out_port)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = '0; in_is_br = '0; dispatch = '0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // present one group; expected index -1 means lane is idle
  task automatic issue(input string req, input logic [3:0] v, input logic [3:0] br,
                       input logic [3:0] dsp, input int e0, input int e1,
                       input int e2, input int e3);
    int exp [4];
    exp = '{e0, e1, e2, e3};
    @(negedge clk);
    in_valid = v; in_is_br = br; dispatch = dsp;
    #1;
    for (int g = 0; g < 4; g++) begin
      chk(req, int'(out_valid[g]), int'(v[g]));
      chk(req, int'(out_port[2*g +: 2]), (exp[g] < 0) ? 0 : exp[g]);
    end
    @(posedge clk);
    #1;
    in_valid = '0; in_is_br = '0; dispatch = '0;
  endtask

  task automatic pulse_dispatch(input logic [3:0] dsp, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      dispatch = dsp;
      @(posedge clk);
      #1;
      dispatch = '0;
    end
  endtask

  task automatic t_reset_state();
    do_reset();
    #1;
    chk("R6 reset idle", int'(out_valid), 0);
    chk("R6 reset idle port", int'(out_port), 0);
    // R1 R2: empty scheduler, lane 3 lands on port 6 (index 3)
    issue("R1", 4'b1111, 4'b0000, 4'b0000, 0, 1, 2, 3);
  endtask

  task automatic t_mixed_group();
    do_reset();
    // R3 R5: branch in lane 1 raises port 6 seen by lanes 2,3
    issue("R5", 4'b1111, 4'b0010, 4'b0000, 0, 3, 1, 2);
    // counts 1,1,1,1 -> tie order 0,1,5,6 (R4)
    issue("R4", 4'b1111, 4'b0000, 4'b0000, 0, 1, 2, 3);
    // counts 2,2,2,2: three branches then ALU -> port 0
    issue("R3", 4'b1111, 4'b0111, 4'b0000, 3, 3, 3, 0);
    // counts 3,2,2,5: ALU picks 1, then 2, then 0 (tie 3,3,3 -> 0)
    issue("R4", 4'b0111, 4'b0000, 4'b0000, 1, 2, 0, -1);
  endtask

  task automatic t_idle_lanes();
    do_reset();
    issue("R6", 4'b0101, 4'b0000, 4'b0000, 0, -1, 1, -1);
    // counts 1,1,0,0 -> lanes to 2,3 then 0,1
    issue("R6", 4'b1111, 4'b0000, 4'b0000, 2, 3, 0, 1);
  endtask

  task automatic t_inc_dec();
    do_reset();
    issue("R7", 4'b1111, 4'b0000, 4'b0000, 0, 1, 2, 3);
    pulse_dispatch(4'b0010, 1);
    // counts 1,0,1,1
    issue("R7", 4'b0011, 4'b0000, 4'b0000, 1, 0, -1, -1);
    // counts 2,1,1,1; issue with same-cycle dispatch of port 1: sees old counts
    issue("R7", 4'b0001, 4'b0000, 4'b0010, 1, -1, -1, -1);
    // counts 2,1,1,1 after +1 -1 on port 1 -> ALU picks 1
    issue("R7", 4'b0001, 4'b0000, 4'b0000, 1, -1, -1, -1);
  endtask

  task automatic t_empty_dispatch();
    do_reset();
    pulse_dispatch(4'b1000, 3);
    // R8: port 6 count must still be zero
    issue("R8", 4'b1111, 4'b0000, 4'b0000, 0, 1, 2, 3);
  endtask

  task automatic t_saturate();
    do_reset();
    for (int k = 0; k < 10; k++) issue("R9 fill", 4'b1111, 4'b1111, 4'b0000, 3, 3, 3, 3);
    // 40 requested, held at 31; drain 30 -> 1
    pulse_dispatch(4'b1000, 30);
    issue("R9", 4'b1111, 4'b0000, 4'b0000, 0, 1, 2, 0);
    // counts 2,1,1,1 -> port 6 usable again at one (R4 tie)
    issue("R9", 4'b0111, 4'b0000, 4'b0000, 1, 2, 3, -1);
  endtask

  task automatic t_comb_timing();
    do_reset();
    @(negedge clk);
    in_valid = 4'b0001; in_is_br = 4'b0001;
    #1;
    chk("R10 same cycle", int'(out_port[1:0]), 3);
    in_is_br = 4'b0000;
    #1;
    chk("R10 same cycle", int'(out_port[1:0]), 0);
    in_valid = '0;
    @(posedge clk);
    #1;
    // nothing was issued at that edge, so tie order is unchanged
    issue("R10", 4'b0001, 4'b0000, 4'b0000, 0, -1, -1, -1);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = '0; in_is_br = '0; dispatch = '0;
    t_reset_state();
    t_mixed_group();
    t_idle_lanes();
    t_inc_dec();
    t_empty_dispatch();
    t_saturate();
    t_comb_timing();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule